// File: doc/BRIEF.md
# DRAM strobe cycle decoder

This block watches the four active-low control strobes of an asynchronous page-mode DRAM (row strobe, column strobe, write strobe and output-enable strobe) from a synchronous clock domain. It works out which kind of memory cycle the controller is running purely from the order in which the strobe edges arrive. It sits as the front end of a small synthesizable DRAM model, or beside a real memory controller as a protocol monitor.

Each strobe passes through a multi-flop synchronizer. A one-sample history register then turns the synchronized levels into rise and fall events. A state machine follows the row/column handshake through plain accesses, page-mode accesses, refresh variants and the gap of a hidden refresh. It emits capture strobes for the row and column addresses, and a level that says when the model may drive its data pins. When the row strobe returns high, it gives a one-cycle, one-hot report of the cycle class. Both row and column strobes changing in the same sample is treated as a protocol violation.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cyc_type` is 8'h80 (only the idle bit set), and `row_capture`, `col_capture`, `dq_drive` and `proto_err` are all 0.
- R2: A row-strobe fall while the column strobe is high pulses `row_capture` for one cycle. If the row strobe then returns high with no column-strobe fall in between, the report is the row-only refresh class, bit 4.
- R3: A column strobe already low when the row strobe falls starts a column-before-row refresh. `row_capture` and `col_capture` stay 0 and `dq_drive` stays 0 whatever the write and output-enable strobes do. The row-strobe rise reports bit 5.
- R4: Each column-strobe fall inside an active row pulses `col_capture`. If the write strobe is low at that fall, the access is an early write, `dq_drive` stays 0 even with output enable low, and the report is bit 1.
- R5: A write-strobe fall after the column-strobe fall, while output enable was low, makes the access a read-modify-write (bit 3). `dq_drive` stays 1 until output enable or the column strobe goes high.
- R6: A write-strobe fall after the column-strobe fall, while output enable was high, makes the access a delayed write (bit 2). `dq_drive` stays 0 for the rest of that access, even if output enable later goes low.
- R7: An access with no write-strobe fall is a read (bit 0). `dq_drive` is 1 only while the column strobe and output enable are both low, and goes to 0 when either returns high.
- R8: Hidden refresh: the column strobe is held low from a read while the row strobe goes high (the read is reported) and low again. `dq_drive` stays 1 while output enable is low, no row is captured, and the second row-strobe rise reports bit 6.
- R9: Cycle reports are one-hot and one clock long, and come only from a row-strobe rise. Bit 7 (idle) is set in every cycle in which the decoder is idle and gives no other report.
- R10: In page mode, several column accesses share one row. Each pulses `col_capture`, and the report at the row-strobe rise gives the class of the last access.
- R11: Row and column strobes changing in the same sample pulse `proto_err`. A simultaneous fall captures nothing and produces no report. The decoder goes idle once both strobes are high.
- R12: Every output reflects a strobe change on the second clock edge after the first edge that samples it, three edges in all with the default two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output-enable strobe, active low, asynchronous |
| cyc_type | output | 8 | One-hot cycle report: 0 read, 1 early write, 2 delayed write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh, 7 idle |
| row_capture | output | 1 | One-cycle pulse: latch the row address now |
| col_capture | output | 1 | One-cycle pulse: latch the column address now |
| dq_drive | output | 1 | Level: data pins may be driven with read data |
| proto_err | output | 1 | One-cycle pulse on simultaneous row and column strobe change |

## Verification
Every result comes out of registers. A strobe level applied between clock edges shows up at the outputs on the third rising edge after it is applied: two synchronizer stages, then the output register. The bench therefore applies each strobe change on a falling clock edge, waits exactly three falling edges, and samples there. That is the only cycle in which a capture pulse, error pulse or cycle report is visible. Levels such as `dq_drive` and the idle bit are checked at the same point, after each step, so every check reads the response to one stimulus with no other edge in flight.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  // strobe bit positions inside the sampled vector
  localparam int NSTB    = 4;
  localparam int S_RAS   = 0;
  localparam int S_CAS   = 1;
  localparam int S_WE    = 2;
  localparam int S_OE    = 3;

  // report bit positions (user visible encoding)
  localparam int NTYPE   = 8;
  localparam int T_READ  = 0;
  localparam int T_EWR   = 1;
  localparam int T_DWR   = 2;
  localparam int T_RMW   = 3;
  localparam int T_RORF  = 4;
  localparam int T_CBRF  = 5;
  localparam int T_HIDF  = 6;
  localparam int T_STBY  = 7;
  localparam int TW      = $clog2(NTYPE);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_CBR, ST_HOLD, ST_ERR
  } dcd_state_e;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int          WIDTH     = 4,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dcd_edge.sv
module dcd_edge #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= cur;
  end

  assign prev = prev_q;
  assign fall = prev_q & ~cur;
  assign rise = ~prev_q & cur;
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTB-1:0]  cur,
  input  logic [NSTB-1:0]  prev,
  input  logic [NSTB-1:0]  fall,
  input  logic [NSTB-1:0]  rise,
  output logic [NTYPE-1:0] cyc_type,
  output logic             row_cap,
  output logic             col_cap,
  output logic             drive,
  output logic             perr
);
  dcd_state_e       state_q, state_d;
  logic [TW-1:0]    cls_q, cls_d;
  logic             colseen_q, colseen_d;
  logic             rd_ok_q, rd_ok_d;
  logic             hid_q, hid_d;
  logic [NTYPE-1:0] rep_d, rep_q;
  logic             rowc_d, rowc_q, colc_d, colc_q, drv_d, drv_q, err_d, err_q;
  logic             ras_chg, cas_chg, both;

  assign ras_chg = fall[S_RAS] | rise[S_RAS];
  assign cas_chg = fall[S_CAS] | rise[S_CAS];
  assign both    = ras_chg & cas_chg;

  always_comb begin
    state_d   = state_q;
    cls_d     = cls_q;
    colseen_d = colseen_q;
    rd_ok_d   = rd_ok_q;
    hid_d     = hid_q;
    rep_d     = '0;
    rowc_d    = 1'b0;
    colc_d    = 1'b0;
    err_d     = both;
    unique case (state_q)
      ST_IDLE: if (fall[S_RAS]) begin
        rd_ok_d = 1'b0;
        if (both) begin
          state_d = ST_ERR;
        end else if (!prev[S_CAS]) begin
          state_d = ST_CBR;
          hid_d   = 1'b0;
        end else begin
          state_d   = ST_ROW;
          rowc_d    = 1'b1;
          colseen_d = 1'b0;
        end
      end
      ST_ROW: begin
        if (rise[S_RAS]) begin
          rep_d[colseen_q ? cls_q : TW'(T_RORF)] = 1'b1;
          state_d = ST_IDLE;
          rd_ok_d = 1'b0;
        end else if (fall[S_CAS]) begin
          state_d   = ST_COL;
          colc_d    = 1'b1;
          colseen_d = 1'b1;
          cls_d     = cur[S_WE] ? TW'(T_READ) : TW'(T_EWR);
          rd_ok_d   = cur[S_WE];
        end
      end
      ST_COL: begin
        if (rise[S_RAS]) begin
          rep_d[cls_q] = 1'b1;
          if (!cur[S_CAS]) begin
            state_d = ST_HOLD;
            rd_ok_d = (cls_q == TW'(T_READ));
          end else begin
            state_d = ST_IDLE;
            rd_ok_d = 1'b0;
          end
        end else begin
          if (fall[S_WE] && cls_q == TW'(T_READ)) begin
            if (!prev[S_OE]) begin
              cls_d = TW'(T_RMW);
            end else begin
              cls_d   = TW'(T_DWR);
              rd_ok_d = 1'b0;
            end
          end
          if (rise[S_CAS]) state_d = ST_ROW;
        end
      end
      ST_HOLD: begin
        if (fall[S_RAS]) begin
          state_d = both ? ST_ERR : ST_CBR;
          hid_d   = rd_ok_q;
        end else if (rise[S_CAS]) begin
          state_d = ST_IDLE;
          rd_ok_d = 1'b0;
        end
      end
      ST_CBR: begin
        if (rise[S_RAS]) begin
          rep_d[hid_q ? TW'(T_HIDF) : TW'(T_CBRF)] = 1'b1;
          if (!cur[S_CAS]) begin
            state_d = ST_HOLD;
          end else begin
            state_d = ST_IDLE;
            rd_ok_d = 1'b0;
          end
        end else if (rise[S_CAS]) begin
          rd_ok_d = 1'b0;
        end
      end
      ST_ERR: if (cur[S_RAS] && cur[S_CAS]) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (state_d == ST_IDLE && rep_d == '0) rep_d[T_STBY] = 1'b1;
    drv_d = (state_d == ST_COL || state_d == ST_HOLD || state_d == ST_CBR) &&
            rd_ok_d && !cur[S_OE] && !cur[S_CAS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cls_q     <= TW'(T_READ);
      colseen_q <= 1'b0;
      rd_ok_q   <= 1'b0;
      hid_q     <= 1'b0;
      rep_q     <= NTYPE'(1) << T_STBY;
      rowc_q    <= 1'b0;
      colc_q    <= 1'b0;
      drv_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cls_q     <= cls_d;
      colseen_q <= colseen_d;
      rd_ok_q   <= rd_ok_d;
      hid_q     <= hid_d;
      rep_q     <= rep_d;
      rowc_q    <= rowc_d;
      colc_q    <= colc_d;
      drv_q     <= drv_d;
      err_q     <= err_d;
    end
  end

  assign cyc_type = rep_q;
  assign row_cap  = rowc_q;
  assign col_cap  = colc_q;
  assign drive    = drv_q;
  assign perr     = err_q;

  // R9: at most one report bit at a time
  assert_type_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rep_q));

  // R9: a non-idle report follows a sampled row-strobe rise
  assert_report_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rep_q & ~(NTYPE'(1) << T_STBY)) != '0) |-> $past(rise[S_RAS]));

  // R3: a row capture never comes from a row fall with the column strobe low
  assert_no_row_in_cbr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rowc_q |-> $past(prev[S_CAS]));

  // R4: an early-write column access leaves the data pins undriven
  assert_early_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (colc_q && $past(!cur[S_WE])) |-> !drv_q);

  // R7: data pins only driven while output enable was sampled low
  assert_drive_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> $past(!cur[S_OE] && !cur[S_CAS]));

  // R10: row and column capture never in the same cycle
  assert_caps_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rowc_q && colc_q));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic [NTYPE-1:0] cyc_type,
  output logic             row_capture,
  output logic             col_capture,
  output logic             dq_drive,
  output logic             proto_err
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [NSTB-1:0]       raw, cur, prev, fall, rise;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  always_comb begin
    raw         = '1;
    raw[S_RAS]  = ras_n;
    raw[S_CAS]  = cas_n;
    raw[S_WE]   = we_n;
    raw[S_OE]   = oe_n;
  end

  dcd_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(raw), .dout(cur)
  );

  dcd_edge #(.WIDTH(NSTB)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .cur(cur), .prev(prev), .fall(fall), .rise(rise)
  );

  dcd_classifier u_cls (
    .clk(clk), .rst_n(rst_int_n), .cur(cur), .prev(prev), .fall(fall), .rise(rise),
    .cyc_type(cyc_type), .row_cap(row_capture), .col_cap(col_capture),
    .drive(dq_drive), .perr(proto_err)
  );
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] cyc_type;
  logic       row_capture, col_capture, dq_drive, proto_err;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  localparam logic [7:0] RD = 8'h01, EW = 8'h02, DW = 8'h04, RMW = 8'h08,
                         RO = 8'h10, CBR = 8'h20, HID = 8'h40, IDLE = 8'h80;

  always #10 clk = ~clk;  // 50 MHz

  dram_cycle_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .cyc_type(cyc_type), .row_capture(row_capture), .col_capture(col_capture),
    .dq_drive(dq_drive), .proto_err(proto_err)
  );

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // apply strobe levels on a falling edge, then wait until the result is due (R12)
  task automatic drv(input logic r, input logic c, input logic w, input logic o);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cyc_type", cyc_type, IDLE);
    chk("R1 row_capture", {7'b0, row_capture}, 8'h0);
    chk("R1 col_capture", {7'b0, col_capture}, 8'h0);
    chk("R1 dq_drive", {7'b0, dq_drive}, 8'h0);
    chk("R1 proto_err", {7'b0, proto_err}, 8'h0);
  endtask

  task automatic t_read();
    drv(0,1,1,1);
    chk("R2 R12 row_capture on row fall", {7'b0, row_capture}, 8'h1);
    chk("R9 no idle while active", cyc_type, 8'h00);
    drv(0,0,1,1);
    chk("R4 col_capture on read", {7'b0, col_capture}, 8'h1);
    chk("R7 no drive with oe high", {7'b0, dq_drive}, 8'h0);
    drv(0,0,1,0);
    chk("R7 drive with cas and oe low", {7'b0, dq_drive}, 8'h1);
    drv(0,0,1,1);
    chk("R7 drive off on oe high", {7'b0, dq_drive}, 8'h0);
    drv(0,0,1,0);
    drv(0,1,1,0);
    chk("R7 drive off on cas high", {7'b0, dq_drive}, 8'h0);
    drv(1,1,1,0);
    chk("R7 R9 read report", cyc_type, RD);
    chk("R11 no error on clean read", {7'b0, proto_err}, 8'h0);
    drv(1,1,1,1);
    chk("R9 idle after report", cyc_type, IDLE);
  endtask

  task automatic t_early_write();
    drv(0,1,0,1);
    drv(0,0,0,0);
    chk("R4 col_capture early write", {7'b0, col_capture}, 8'h1);
    chk("R4 no drive in early write", {7'b0, dq_drive}, 8'h0);
    drv(0,1,0,0);
    drv(1,1,0,0);
    chk("R4 early write report", cyc_type, EW);
    drv(1,1,1,1);
  endtask

  task automatic t_rmw();
    drv(0,1,1,1);
    drv(0,0,1,1);
    drv(0,0,1,0);
    chk("R5 read part drives", {7'b0, dq_drive}, 8'h1);
    drv(0,0,0,0);
    chk("R5 drive held after write fall", {7'b0, dq_drive}, 8'h1);
    drv(0,0,0,1);
    chk("R5 drive off on oe high", {7'b0, dq_drive}, 8'h0);
    drv(0,1,0,1);
    drv(1,1,0,1);
    chk("R5 rmw report", cyc_type, RMW);
    drv(1,1,1,1);
  endtask

  task automatic t_delayed_write();
    drv(0,1,1,1);
    drv(0,0,1,1);
    drv(0,0,0,1);
    chk("R6 no drive after delayed write", {7'b0, dq_drive}, 8'h0);
    drv(0,0,0,0);
    chk("R6 oe low ignored after delayed write", {7'b0, dq_drive}, 8'h0);
    drv(0,1,0,0);
    drv(1,1,0,0);
    chk("R6 delayed write report", cyc_type, DW);
    drv(1,1,1,1);
  endtask

  task automatic t_ras_only();
    drv(0,1,1,1);
    chk("R2 row_capture ras-only", {7'b0, row_capture}, 8'h1);
    drv(1,1,1,1);
    chk("R2 ras-only report", cyc_type, RO);
  endtask

  task automatic t_cbr();
    drv(1,0,0,0);
    chk("R3 idle with column strobe only", cyc_type, IDLE);
    drv(0,0,0,0);
    chk("R3 no row capture", {7'b0, row_capture}, 8'h0);
    chk("R3 no col capture", {7'b0, col_capture}, 8'h0);
    chk("R3 no drive", {7'b0, dq_drive}, 8'h0);
    drv(1,0,0,0);
    chk("R3 cbr report", cyc_type, CBR);
    drv(1,1,1,1);
    chk("R3 idle after cbr", cyc_type, IDLE);
  endtask

  task automatic t_hidden();
    drv(0,1,1,1);
    drv(0,0,1,1);
    drv(0,0,1,0);
    drv(1,0,1,0);
    chk("R8 read reported first", cyc_type, RD);
    chk("R8 drive held across row gap", {7'b0, dq_drive}, 8'h1);
    drv(0,0,1,0);
    chk("R8 no row capture", {7'b0, row_capture}, 8'h0);
    chk("R8 drive held in refresh", {7'b0, dq_drive}, 8'h1);
    drv(1,0,1,0);
    chk("R8 hidden report", cyc_type, HID);
    drv(1,1,1,0);
    chk("R8 drive off on cas high", {7'b0, dq_drive}, 8'h0);
    drv(1,1,1,1);
  endtask

  task automatic t_page();
    drv(0,1,1,1);
    drv(0,0,1,1);
    chk("R10 first col_capture", {7'b0, col_capture}, 8'h1);
    drv(0,1,1,1);
    drv(0,0,0,1);
    chk("R10 second col_capture", {7'b0, col_capture}, 8'h1);
    drv(0,1,0,1);
    drv(1,1,0,1);
    chk("R10 last access class", cyc_type, EW);
    drv(1,1,1,1);
  endtask

  task automatic t_proto();
    drv(0,0,1,1);
    chk("R11 error on joint fall", {7'b0, proto_err}, 8'h1);
    chk("R11 no row capture", {7'b0, row_capture}, 8'h0);
    chk("R11 no col capture", {7'b0, col_capture}, 8'h0);
    drv(1,1,1,1);
    chk("R11 error on joint rise", {7'b0, proto_err}, 8'h1);
    chk("R11 no report, idle", cyc_type, IDLE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_read();
    t_early_write();
    t_rmw();
    t_delayed_write();
    t_ras_only();
    t_cbr();
    t_hidden();
    t_page();
    t_proto();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule